// File: doc/BRIEF.md
# Configurable 16-Pin GPIO Bank

This block controls sixteen general-purpose pins arranged as two groups of eight. Each pin has three settings: a direction, a polarity inversion and an output style, which is either driven both ways or pull-low only. Software sets these through an indexed configuration port. Each write names an 8-bit register index and gives one byte for a whole group. A second, runtime port answers to addresses counted from a base that is supplied as an input. At fixed offsets from that base it exposes one data byte per group.

A write to a data byte stores new values only in the output latches of pins that are currently outputs. The latches of input pins keep their old values. A read returns the synchronized level seen at the pad, with the pin's inversion applied, whatever the pin's direction. The pad side of the block has three vectors: a per-pin drive value, a per-pin enable, and the sampled pad level. The pad level passes through two flops before it reaches the read path.

Reads are sequenced by a two-state machine. In RT_IDLE, a read that hits a data offset captures the group's value and moves to RT_RESP. In RT_RESP the response is valid for one cycle. The machine stays in RT_RESP if another hitting read arrives in that cycle, and returns to RT_IDLE otherwise.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every pin is an input with no inversion and drive-both-ways style, every output latch is 0, and pad_oe and pad_out are all 0.
- R2: For group g (0 or 1), a configuration write sets direction at index 0x31+4g, inversion at 0x32+4g and style at 0x33+4g, with bit k controlling pin 8g+k. A write to any other index changes nothing.
- R3: A pin with direction 1 and style 0 has pad_oe=1 and pad_out equal to its latch XOR its inversion bit.
- R4: A pin with direction 1 and style 1 (open-drain) has pad_out=0 and pad_oe=1 only while the inverted latch value is 0.
- R5: A pin with direction 0 has pad_oe=0 and pad_out=0.
- R6: The data byte of group g sits at rt_base+0x0C+2g. Runtime reads or writes at any other address have no effect, and a read there gives no response.
- R7: A data write loads bit k into the latch of pin 8g+k only if that pin's direction bit is 1. The latches of input pins are unchanged.
- R8: A read that hits is followed one cycle later by rd_valid=1. rd_data then holds the group's synchronized pad levels XOR the inversion bits, for input and output pins alike.
- R9: A pad level change becomes visible to a read captured at the third rising edge after the change, and not to one captured at the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write byte |
| rt_base | input | 16 | Decoded base of the runtime window |
| io_addr | input | 16 | Runtime address |
| io_wr | input | 1 | Runtime write strobe |
| io_rd | input | 1 | Runtime read strobe |
| io_wdata | input | 8 | Runtime write byte |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Read response byte |
| pad_in | input | 16 | Sampled pad levels |
| pad_out | output | 16 | Per-pin drive value |
| pad_oe | output | 16 | Per-pin output enable |

## Verification
The assertions check several rules on every cycle. An input pin never enables its pad. An open-drain pin never drives a high value. A data write leaves the latch of every input pin unchanged. A hitting read is always followed by a valid response. The bench's scenarios are needed for the rest: the index map, the address offsets, the values read under inversion and the exact synchronizer latency. It also shows indirect effects, such as a latch written while its pin was an input becoming visible only once the pin turns into an output.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic {
        RT_IDLE = 1'b0,
        RT_RESP = 1'b1
    } rt_state_t;

    localparam int unsigned DEF_GROUPS       = 2;
    localparam int unsigned DEF_PINS_PER_GRP = 8;
    localparam int unsigned DEF_CFG_BASE     = 'h31;
    localparam int unsigned DEF_CFG_STRIDE   = 4;
    localparam int unsigned DEF_DATA_OFF     = 'h0C;
    localparam int unsigned DEF_DATA_STRIDE  = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int unsigned GROUPS     = 2,
    parameter int unsigned PPG        = 8,
    parameter int unsigned IDX_W      = 8,
    parameter int unsigned CFG_BASE   = 'h31,
    parameter int unsigned CFG_STRIDE = 4,
    parameter int unsigned GRP_W      = 1,
    localparam int unsigned NPINS     = GROUPS * PPG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [PPG-1:0]   cfg_wdata,
    input  logic             dat_we,
    input  logic [GRP_W-1:0] dat_grp,
    input  logic [PPG-1:0]   dat_wdata,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] pol_q,
    output logic [NPINS-1:0] typ_q,
    output logic [NPINS-1:0] lat_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            pol_q <= '0;
            typ_q <= '0;
            lat_q <= '0;
        end else begin
            for (int g = 0; g < int'(GROUPS); g++) begin
                if (cfg_we && cfg_idx == IDX_W'(CFG_BASE + g * CFG_STRIDE))
                    dir_q[g*PPG +: PPG] <= cfg_wdata;
                if (cfg_we && cfg_idx == IDX_W'(CFG_BASE + g * CFG_STRIDE + 1))
                    pol_q[g*PPG +: PPG] <= cfg_wdata;
                if (cfg_we && cfg_idx == IDX_W'(CFG_BASE + g * CFG_STRIDE + 2))
                    typ_q[g*PPG +: PPG] <= cfg_wdata;
                if (dat_we && dat_grp == GRP_W'(g))
                    lat_q[g*PPG +: PPG] <= (lat_q[g*PPG +: PPG] & ~dir_q[g*PPG +: PPG])
                                         | (dat_wdata & dir_q[g*PPG +: PPG]);
            end
        end
    end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int unsigned NPINS = 16
) (
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] typ,
    input  logic [NPINS-1:0] lat,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic level;
        assign level      = lat[i] ^ pol[i];
        assign pad_oe[i]  = dir[i] & (~typ[i] | ~level);
        assign pad_out[i] = dir[i] & ~typ[i] & level;
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int unsigned GROUPS      = DEF_GROUPS,
    parameter int unsigned PPG         = DEF_PINS_PER_GRP,
    parameter int unsigned IDX_W       = 8,
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned CFG_BASE    = DEF_CFG_BASE,
    parameter int unsigned CFG_STRIDE  = DEF_CFG_STRIDE,
    parameter int unsigned DATA_OFF    = DEF_DATA_OFF,
    parameter int unsigned DATA_STRIDE = DEF_DATA_STRIDE,
    localparam int unsigned NPINS      = GROUPS * PPG,
    localparam int unsigned GRP_W      = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [PPG-1:0]    cfg_wdata,
    input  logic [ADDR_W-1:0] rt_base,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [PPG-1:0]    io_wdata,
    output logic              rd_valid,
    output logic [PPG-1:0]    rd_data,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);
    logic [ADDR_W-1:0] rel_addr;
    logic              hit;
    logic [GRP_W-1:0]  grp;
    logic              rd_hit;
    logic              wr_hit;
    logic [NPINS-1:0]  dir_q, pol_q, typ_q, lat_q;
    logic [NPINS-1:0]  pad_sync;
    logic [NPINS-1:0]  rd_view;
    rt_state_t         state_q, state_d;

    assign rel_addr = io_addr - rt_base;

    always_comb begin
        hit = 1'b0;
        grp = '0;
        for (int g = 0; g < int'(GROUPS); g++) begin
            if (rel_addr == ADDR_W'(DATA_OFF + g * DATA_STRIDE)) begin
                hit = 1'b1;
                grp = GRP_W'(g);
            end
        end
    end

    assign rd_hit = io_rd & hit;
    assign wr_hit = io_wr & hit;

    gpio_regs #(
        .GROUPS(GROUPS), .PPG(PPG), .IDX_W(IDX_W),
        .CFG_BASE(CFG_BASE), .CFG_STRIDE(CFG_STRIDE), .GRP_W(GRP_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .dat_we(wr_hit), .dat_grp(grp), .dat_wdata(io_wdata),
        .dir_q(dir_q), .pol_q(pol_q), .typ_q(typ_q), .lat_q(lat_q)
    );

    gpio_sync #(.WIDTH(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
    );

    gpio_pad_ctrl #(.NPINS(NPINS)) u_pads (
        .dir(dir_q), .pol(pol_q), .typ(typ_q), .lat(lat_q),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    assign rd_view = pad_sync ^ pol_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RT_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        rd_valid = 1'b0;
        unique case (state_q)
            RT_IDLE: begin
                if (rd_hit) state_d = RT_RESP;
            end
            RT_RESP: begin
                rd_valid = 1'b1;
                state_d  = rd_hit ? RT_RESP : RT_IDLE;
            end
            default: state_d = RT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_hit) rd_data <= rd_view[grp*PPG +: PPG];
    end

    AST_INPUT_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_q) == '0);  // R5
    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & typ_q) == '0);  // R4
    AST_INPUT_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ((lat_q ^ $past(lat_q)) & ~$past(dir_q)) == '0);  // R7
    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> rd_valid);  // R8
    AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> !rd_valid);  // R6
endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
    localparam logic [15:0] RTB = 16'h0A00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_idx = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [15:0] pad_in, pad_out, pad_oe;
    logic [15:0] ext = 16'hFFFF;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_bank i_gpio_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .rt_base(RTB), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // behavioural reference model
    logic [15:0] m_dir = '0, m_pol = '0, m_typ = '0, m_lat = '0;
    logic [15:0] m_s1 = '0, m_s2 = '0;
    logic        m_rv = 1'b0;
    logic [7:0]  m_rd = '0;

    function automatic int grp_of(logic [15:0] a);
        logic [15:0] off = a - RTB;
        if (off == 16'h000C) return 0;
        if (off == 16'h000E) return 1;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = '0; m_pol = '0; m_typ = '0; m_lat = '0;
            m_s1 = '0; m_s2 = '0; m_rv = 1'b0; m_rd = '0;
        end else begin
            int g;
            logic [15:0] view;
            logic nv;
            nv = 1'b0;
            g = grp_of(io_addr);
            view = m_s2 ^ m_pol;
            if (io_rd && g >= 0) begin
                nv = 1'b1;
                m_rd = view[g*8 +: 8];
            end
            if (io_wr && g >= 0) begin
                for (int k = 0; k < 8; k++)
                    if (m_dir[g*8+k]) m_lat[g*8+k] = io_wdata[k];
            end
            if (cfg_we) begin
                for (int q = 0; q < 2; q++) begin
                    if (cfg_idx == 8'(8'h31 + 4*q)) m_dir[q*8 +: 8] = cfg_wdata;
                    if (cfg_idx == 8'(8'h32 + 4*q)) m_pol[q*8 +: 8] = cfg_wdata;
                    if (cfg_idx == 8'(8'h33 + 4*q)) m_typ[q*8 +: 8] = cfg_wdata;
                end
            end
            m_s2 = m_s1;
            m_s1 = pad_in;
            m_rv = nv;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // compare with the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [15:0] lvl, eoe, eout;
            lvl  = m_lat ^ m_pol;
            eoe  = m_dir & (~m_typ | ~lvl);
            eout = m_dir & ~m_typ & lvl;
            check("R3/R4/R5 pad_oe", {16'h0, pad_oe}, {16'h0, eoe});
            check("R3/R4/R5 pad_out", {16'h0, pad_out}, {16'h0, eout});
            check("R6/R8 rd_valid", {31'h0, rd_valid}, {31'h0, m_rv});
            if (m_rv) check("R8 rd_data", {24'h0, rd_data}, {24'h0, m_rd});
        end
    end

    task automatic cfg_wr(logic [7:0] idx, logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic io_write(logic [15:0] off, logic [7:0] v);
        @(negedge clk); io_wr = 1'b1; io_addr = RTB + off; io_wdata = v;
        @(negedge clk); io_wr = 1'b0;
    endtask

    // returns with rd_valid/rd_data settled for the response cycle
    task automatic io_read(logic [15:0] off);
        @(negedge clk); io_rd = 1'b1; io_addr = RTB + off;
        @(negedge clk); io_rd = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        ext = 16'hA55A;
        idle(3);
        check("R1 pad_oe reset", {16'h0, pad_oe}, 32'h0);
        check("R1 pad_out reset", {16'h0, pad_out}, 32'h0);
        rst_n = 1'b1;
        idle(3);
        // R8 read of input pins
        io_read(16'h0E);
        check("R8 read group1 inputs", {31'h0, rd_valid, 24'h0, rd_data}, {31'h0, 1'b1, 24'h0, 8'hA5});
        // R2 stray indices change nothing
        cfg_wr(8'h34, 8'hFF);
        cfg_wr(8'h30, 8'hFF);
        check("R2 stray index", {16'h0, pad_oe}, 32'h0);
        // R3 push-pull on group 0
        cfg_wr(8'h31, 8'hFF);
        io_write(16'h0C, 8'h3C);
        check("R3 push-pull out", {24'h0, pad_out[7:0]}, 32'h3C);
        check("R3 push-pull oe", {24'h0, pad_oe[7:0]}, 32'hFF);
        cfg_wr(8'h32, 8'h0F);
        check("R3 inverted out", {24'h0, pad_out[7:0]}, 32'h33);
        idle(3);
        io_read(16'h0C);
        check("R8 read output pins", {24'h0, rd_data}, 32'h3C);
        // R6 off-window accesses
        io_write(16'h0D, 8'h00);
        check("R6 stray write", {24'h0, pad_out[7:0]}, 32'h33);
        io_read(16'h0D);
        check("R6 stray read", {31'h0, rd_valid}, 32'h0);
        // R4 open-drain on group 1
        cfg_wr(8'h37, 8'hFF);
        cfg_wr(8'h35, 8'hFF);
        io_write(16'h0E, 8'hF0);
        check("R4 od oe", {24'h0, pad_oe[15:8]}, 32'h0F);
        check("R4 od out", {24'h0, pad_out[15:8]}, 32'h00);
        // R7 partial direction write
        cfg_wr(8'h35, 8'h0F);
        io_write(16'h0E, 8'h0F);
        cfg_wr(8'h35, 8'hFF);
        check("R7 input latches kept", {24'h0, pad_oe[15:8]}, 32'h00);
        // R5 back to inputs
        cfg_wr(8'h31, 8'h00);
        check("R5 input oe", {24'h0, pad_oe[7:0]}, 32'h00);
        check("R5 input out", {24'h0, pad_out[7:0]}, 32'h00);
        // R9 synchronizer latency, group 0 inputs, pol 0x0F
        ext[7:0] = 8'h00;
        idle(4);
        @(negedge clk); ext[7:0] = 8'hFF; io_rd = 1'b1; io_addr = RTB + 16'h0C;
        @(negedge clk); io_rd = 1'b0;
        check("R9 early read old", {24'h0, rd_data}, 32'h0F);
        @(negedge clk); io_rd = 1'b1;
        @(negedge clk); io_rd = 1'b0;
        check("R9 third edge new", {24'h0, rd_data}, 32'hF0);
        // back-to-back reads
        @(negedge clk); io_rd = 1'b1; io_addr = RTB + 16'h0C;
        @(negedge clk); io_addr = RTB + 16'h0E;
        @(negedge clk); io_rd = 1'b0;
        check("R8 back-to-back valid", {31'h0, rd_valid}, 32'h1);
        idle(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule